// File: doc/BRIEF.md
# Bus Operation Timeout Timer

This block guards one channel of a descriptor engine. It limits how long a single bus read or write may stay outstanding. The engine pulses `op_start` when it issues a bus operation and `op_done` when the operation completes. If the operation is still outstanding when the configured time runs out, the block sets a sticky timeout flag. It also raises a one-cycle event pulse when the flag is set. The flag stays set until the engine pulses `flag_clr`.

The duration is built in two stages. The first is a power-of-two prescaler. Its select chooses one of: off, 2^(1·STEP), 2^(2·STEP) or 2^(3·STEP) engine clocks per tick, where STEP is 8 in silicon. The second is a tick counter that needs 2^(t+2) ticks, which gives 4 to 512 ticks. Both selects are captured when an operation starts, and both counters restart from zero at that point. The `PRE_STEP` parameter exists only so that a simulation can shrink the prescaler exponents.

The control state machine has four states:
- `ST_IDLE`: no operation is outstanding.
- `ST_TIMED`: an operation is outstanding and being timed.
- `ST_UNTIMED`: an operation is outstanding with the prescaler off.
- `ST_LAPSED`: the time ran out and the operation is still outstanding.

Its transitions are:
- start: any state goes to `ST_TIMED` or `ST_UNTIMED`, depending on the prescale code.
- complete: `ST_TIMED`, `ST_UNTIMED` or `ST_LAPSED` goes to `ST_IDLE` on `op_done`.
- expire: `ST_TIMED` goes to `ST_LAPSED` on the final tick without `op_done`.

Top module: `bus_op_timeout`

## Requirements
- R1: After reset, `to_flag` and `to_event` are 0.
- R2: With prescale code p in 1..3 and tick code t in 0..7, take the `op_start` edge as edge 0. `to_flag` rises exactly at clock edge 2^(STEP·p) · 2^(t+2) counted from edge 0, if no `op_done` has been sampled by that edge.
- R3: If `op_done` is sampled at or before the expiry edge, including on the expiry edge itself, the flag is not set.
- R4: Prescale code 0 means off. No timeout fires for that operation, whatever the tick code or however long the operation lasts.
- R5: `pre_sel` and `tick_sel` are sampled only on the `op_start` edge. Changing them while an operation is outstanding has no effect on its duration.
- R6: `to_flag` stays 1 until `flag_clr` is sampled, and it reads 0 on the cycle after that. If a set and a clear happen on the same edge, the set wins.
- R7: `to_event` is high for exactly one cycle, in the same cycle in which `to_flag` rises.
- R8: An `op_start` while an operation is outstanding restarts the measurement from zero, using the newly sampled selects.
- R9: An operation raises at most one `to_event`, even if it stays outstanding long after the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_start | input | 1 | One-cycle pulse: a bus operation was issued |
| op_done | input | 1 | One-cycle pulse: the bus operation completed |
| pre_sel | input | 2 | Prescale code: 0 off, 1/2/3 give 2^(STEP·code) clocks per tick |
| tick_sel | input | 3 | Tick code t: 2^(t+2) ticks |
| flag_clr | input | 1 | One-cycle pulse that clears the timeout flag |
| to_flag | output | 1 | Sticky timeout flag |
| to_event | output | 1 | One-cycle pulse when the flag is set |

## Verification
A prescaler or tick counter that is not cleared on start, or that wraps at the wrong value, moves the rising edge of `to_flag` away from the exact expected cycle. The bench compares the flag on every cycle of an operation, so such a fault shows within one tick period of the expected expiry. A wrong state transition appears in one of three ways: an event for a completed or untimed operation, a second event for one operation, or a flag that drops without a clear. Each of these is visible on the cycle it happens.

// File: rtl/bus_to_pkg.sv
package bus_to_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_TIMED    = 2'd1,
        ST_UNTIMED  = 2'd2,
        ST_LAPSED   = 2'd3
    } to_state_e;

    localparam logic [1:0] PRE_CODE_OFF = 2'd0;
endpackage

// File: rtl/to_prescaler.sv
module to_prescaler #(
    parameter int PRE_STEP = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int CW = 3 * PRE_STEP;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_val;

    // terminal value 2^(PRE_STEP*sel) - 1
    always_comb begin
        last_val = {CW{1'b1}} >> (CW - int'(sel) * PRE_STEP);
    end

    assign tick = run && (cnt_q == last_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || tick) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/to_tick_counter.sv
module to_tick_counter #(
    parameter int TSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              adv,
    input  logic [TSEL_W-1:0] sel,
    output logic              final_tick
);
    localparam int TW = (1 << TSEL_W) + 1;

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] last_val;

    // terminal value 2^(sel+2) - 1
    always_comb begin
        last_val = {TW{1'b1}} >> (TW - (int'(sel) + 2));
    end

    assign final_tick = adv && (cnt_q == last_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || final_tick) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bus_op_timeout.sv
module bus_op_timeout
    import bus_to_pkg::*;
#(
    parameter int PRE_STEP = 8,
    parameter int TSEL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_done,
    input  logic [1:0]        pre_sel,
    input  logic [TSEL_W-1:0] tick_sel,
    input  logic              flag_clr,
    output logic              to_flag,
    output logic              to_event
);
    to_state_e         state_q, state_d;
    logic [1:0]        pre_q;
    logic [TSEL_W-1:0] tick_q;
    logic              pre_tick;
    logic              expire;
    logic              set_now;
    logic              flag_q, event_q;

    // selects captured only at operation start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= PRE_CODE_OFF;
            tick_q <= '0;
        end else if (op_start) begin
            pre_q  <= pre_sel;
            tick_q <= tick_sel;
        end
    end

    to_prescaler #(.PRE_STEP(PRE_STEP)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (op_start),
        .run   (state_q == ST_TIMED),
        .sel   (pre_q),
        .tick  (pre_tick)
    );

    to_tick_counter #(.TSEL_W(TSEL_W)) u_ticks (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (op_start),
        .adv        (pre_tick),
        .sel        (tick_q),
        .final_tick (expire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (op_start) begin
            state_d = (pre_sel == PRE_CODE_OFF) ? ST_UNTIMED : ST_TIMED;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_TIMED: begin
                    if (op_done)     state_d = ST_IDLE;
                    else if (expire) state_d = ST_LAPSED;
                end
                ST_UNTIMED: if (op_done) state_d = ST_IDLE;
                ST_LAPSED:  if (op_done) state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // outputs: completion or restart on the final edge wins over expiry
    assign set_now = (state_q == ST_TIMED) && expire && !op_done && !op_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            event_q <= 1'b0;
        end else begin
            event_q <= set_now;
            if (set_now)       flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign to_flag  = flag_q;
    assign to_event = event_q;
endmodule

// File: rtl/bus_op_timeout_chk.sv
module bus_op_timeout_chk
    import bus_to_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      op_start,
    input logic      op_done,
    input logic      flag_clr,
    input logic      to_flag,
    input logic      to_event,
    input to_state_e state_q
);
    AST_EVENT_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        to_event |-> to_flag); // R7
    AST_EVENT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        to_event |=> !to_event); // R9
    AST_RISE_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag) |-> to_event); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag && !flag_clr) |=> to_flag); // R6
    AST_UNTIMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNTIMED) |=> !to_event); // R4
    AST_DONE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TIMED && op_done) |=> !to_event); // R3
    AST_LAPSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAPSED && !op_start) |=> !to_event); // R9
endmodule

bind bus_op_timeout bus_op_timeout_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_start (op_start),
    .op_done  (op_done),
    .flag_clr (flag_clr),
    .to_flag  (to_flag),
    .to_event (to_event),
    .state_q  (state_q)
);

// File: tb/bus_op_timeout_test.sv
`timescale 1ns/1ps
module bus_op_timeout_test;
    localparam int STEP = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start = 1'b0;
    logic       op_done = 1'b0;
    logic [1:0] pre_sel = 2'd0;
    logic [2:0] tick_sel = 3'd0;
    logic       flag_clr = 1'b0;
    logic       to_flag;
    logic       to_event;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bus_op_timeout #(.PRE_STEP(STEP), .TSEL_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_done(op_done),
        .pre_sel(pre_sel), .tick_sel(tick_sel), .flag_clr(flag_clr),
        .to_flag(to_flag), .to_event(to_event)
    );

    function automatic int dur(input int p, input int t);
        if (p == 0) return 1 << 30;
        return 1 << (STEP * p + t + 2);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // d: cycle (edge index after start) at which op_done is sampled
    // rs: edge at which a restart is sampled (0 = none)
    // ca: edge at which flag_clr is sampled (0 = none)
    task automatic run_op(input string req, input int p, input int t,
                          input int d, input int rs, input int ca);
        int tt, lim, evn, first_k, act_f, exp_f;
        bit timed_out, ok;
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        check({req, " R6 clear"}, int'(to_flag), 0);
        pre_sel = 2'(p); tick_sel = 3'(t); op_start = 1'b1;
        @(negedge clk) op_start = 1'b0;
        tt = (p == 0) ? (1 << 30) : rs + dur(p, t);
        timed_out = d > tt;
        lim = (timed_out ? d : (d > 0 ? d : tt)) + 3;
        evn = 0; ok = 1'b1; first_k = 0; act_f = 0; exp_f = 0;
        for (int k = 1; k <= lim; k++) begin
            op_done  = (k == d);
            op_start = (rs != 0 && k == rs);
            flag_clr = (ca != 0 && k == ca);
            if (op_start) begin
                pre_sel = 2'(p); tick_sel = 3'(t);
            end else begin
                pre_sel = 2'($urandom); tick_sel = 3'($urandom); // R5
            end
            @(posedge clk);
            @(negedge clk);
            if (to_event) evn++;
            if (ok && ((int'(to_flag) != int'(timed_out && k >= tt)) ||
                       (int'(to_event) != int'(timed_out && k == tt)))) begin
                ok = 1'b0; first_k = k; act_f = int'(to_flag);
                exp_f = int'(timed_out && k >= tt);
            end
        end
        op_done = 1'b0; op_start = 1'b0; flag_clr = 1'b0;
        if (!ok) $display("FAIL %s R2/R3 at cycle %0d flag actual=%0d expected=%0d",
                          req, first_k, act_f, exp_f);
        check({req, " R2 timing"}, int'(ok), 1);
        check({req, " R9 event count"}, evn, timed_out ? 1 : 0);
        if (timed_out) begin
            repeat (5) @(negedge clk);
            check({req, " R6 sticky"}, int'(to_flag), 1);
        end
    endtask

    initial begin
        int p, t, d, dd, mode;
        void'($urandom(32'd1234));
        #1;
        check("R1 flag after reset", int'(to_flag), 0);
        check("R1 event after reset", int'(to_event), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 flag idle", int'(to_flag), 0);

        // directed corners
        run_op("R2 min", 1, 0, 40, 0, 0);          // 16 cycles
        run_op("R3 same edge", 1, 0, 16, 0, 0);
        run_op("R3 one early", 1, 1, 31, 0, 0);
        run_op("R2 one late", 1, 1, 33, 0, 0);
        run_op("R4 off", 0, 7, 3000, 0, 0);
        run_op("R5 sampled", 2, 0, 100, 0, 0);      // 64 cycles
        run_op("R8 restart", 1, 0, 60, 10, 0);      // expires at 26
        run_op("R8 restart late", 1, 2, 120, 60, 0);// expires at 124 -> done wins
        run_op("R6 set beats clear", 1, 0, 30, 0, 16);
        run_op("R9 long lapse", 1, 0, 200, 0, 0);
        run_op("R2 max", 3, 7, 32769, 0, 0);

        // random operations
        for (int i = 0; i < 40; i++) begin
            p = $urandom % 4;
            t = $urandom % 8;
            while (p != 0 && dur(p, t) > 1024) t--;
            dd = (p == 0) ? 300 : dur(p, t);
            mode = $urandom % 4;
            case (mode)
                0: d = dd;
                1: d = dd + 1;
                2: d = (dd > 1) ? dd - 1 : 1;
                default: d = 1 + ($urandom % (dd + 20));
            endcase
            run_op("R2/R3 random", p, t, d, 0, 0);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule